// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block drives a memory self-test. A 16-bit configuration register is loaded serially while a shift enable is held high. A rising edge on the run input then starts a March C- algorithm. The sequencer issues one 12-bit command word per clock to a separate memory-side dispatch unit, which owns the address counters and the data compare. The dispatch unit answers on a 3-bit response bus: an address-expire flag, a pipeline-empty flag and a per-compare fail flag.

The algorithm is a fixed list of six march elements. Each element opens with a reset-address command. It then walks every address with one or two read/write operations, and it closes when the dispatch unit reports address expiry on an increment. After the last element, the sequencer stalls until the compare pipeline has drained. Only then does it raise completion, so late compare results are still counted.

A 3-bit status bus reports three things: element progress, failures (either sticky or one pulse per failing compare) and completion.

Top module: `mbist_sequencer`

## Requirements
- R1: When rst_n is low, and on the cycle after any cycle with bist_en low, cmd is all zero and status is all zero. While bist_en is low, cmd stays zero and the configuration register ignores ir_shift and ser_in.
- R2: While bist_en and ir_shift are high and no test is running, each clock shifts the configuration register one place LSB first: ser_in enters bit 15 and bit 0 leaves. cmd[3] shows the current bit 0, and every other cmd bit is 0.
- R3: Configuration bit 0 sets cmd[4] (checkerboard data) and bit 1 sets cmd[7] (row-fast). Both apply to every command of a run. Configuration bit 5 selects the fail-report mode.
- R4: A rising edge on run, with bist_en high, ir_shift low and no test running, starts a test. The first command appears in the next cycle, and in that same cycle status[1] and status[2] are already cleared.
- R5: Each element opens with one command that has cmd[0] (reset address) set. In that command, cmd[8] is 1 for descending elements (the fourth and fifth) and 0 otherwise.
- R6: For each address, the sequencer issues the element's operations in order, one per cycle. The elements are: write 0; read 0 then write 1; read 1 then write 0; the same two pairs descending; and read 0. A read sets cmd[6], a write sets cmd[5], and cmd[3] carries the data value. The last operation of each address also sets cmd[1] (increment). cmd[8] follows the element direction.
- R7: When rsp[0] is high in a cycle that carries cmd[1], the element ends. The next cycle opens the following element with cmd[0].
- R8: status[0] is high for exactly the one cycle after each element end. A full run gives six pulses.
- R9: After the last element, every command carries cmd[11] (stall) until a stall cycle sees rsp[1] high. From the next cycle, cmd is zero and status[2] stays high until the next start.
- R10: With configuration bit 5 clear, rsp[2] in any command cycle sets status[1] from the next cycle until the next start.
- R11: With configuration bit 5 set, status[1] equals rsp[2] of the previous cycle while a test runs, giving one pulse per failing compare.
- R12: cmd[2], cmd[9] and cmd[10] (spare row, bitmap, go/no-go select) are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bist_en | input | 1 | Self-test path enable |
| ser_in | input | 1 | Serial configuration data |
| ir_shift | input | 1 | Configuration shift enable |
| run | input | 1 | Test start (rising edge) |
| rsp | input | 3 | Dispatch response: expire, pipeline empty, fail |
| cmd | output | 12 | Per-cycle command word to the dispatch unit |
| status | output | 3 | Status: element progress, fail, done |

## Verification
The bench builds the block with its default parameters: a 16-bit register shifted LSB first, and the fail-mode bit at position 5. It pairs the block with a four-address dispatch model, so a whole March C- run takes about fifty cycles. This keeps every element boundary, the descending elements, the drain stall and failures injected both mid-march and during the drain within reach of short runs in both fail-report modes. Two back-to-back register loads expose the serial data leaving on cmd[3]. A load attempted while the block is disabled shows up as an unchanged register on the next shift-out.

// File: rtl/mbist_seq_pkg.sv
package mbist_seq_pkg;

   localparam int CMD_W  = 12;
   localparam int RSP_W  = 3;
   localparam int STAT_W = 3;

   // command word bit positions (decoded by the dispatch unit)
   localparam int C_RST   = 0;
   localparam int C_INC   = 1;
   localparam int C_SPARE = 2;
   localparam int C_INV   = 3;
   localparam int C_CKB   = 4;
   localparam int C_WR    = 5;
   localparam int C_RD    = 6;
   localparam int C_ROWF  = 7;
   localparam int C_DOWN  = 8;
   localparam int C_BMAP  = 9;
   localparam int C_GNG   = 10;
   localparam int C_STALL = 11;

   // response and status positions
   localparam int R_EXP   = 0;
   localparam int R_EMPTY = 1;
   localparam int R_FAIL  = 2;
   localparam int S_EXP   = 0;
   localparam int S_FAIL  = 1;
   localparam int S_DONE  = 2;

   localparam int NUM_ELEM = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ELEM,
      ST_OP,
      ST_DRAIN,
      ST_DONE
   } seq_state_e;

   typedef struct packed {
      logic down;
      logic two_ops;
      logic op0_rd;
      logic op0_val;
      logic op1_val;
   } march_elem_t;

   // March C- element list; op1 is always a write
   function automatic march_elem_t march_elem(input int unsigned idx);
      march_elem_t e;
      case (idx)
         0:       e = '{down: 1'b0, two_ops: 1'b0, op0_rd: 1'b0, op0_val: 1'b0, op1_val: 1'b0};
         1:       e = '{down: 1'b0, two_ops: 1'b1, op0_rd: 1'b1, op0_val: 1'b0, op1_val: 1'b1};
         2:       e = '{down: 1'b0, two_ops: 1'b1, op0_rd: 1'b1, op0_val: 1'b1, op1_val: 1'b0};
         3:       e = '{down: 1'b1, two_ops: 1'b1, op0_rd: 1'b1, op0_val: 1'b0, op1_val: 1'b1};
         4:       e = '{down: 1'b1, two_ops: 1'b1, op0_rd: 1'b1, op0_val: 1'b1, op1_val: 1'b0};
         default: e = '{down: 1'b0, two_ops: 1'b0, op0_rd: 1'b1, op0_val: 1'b0, op1_val: 1'b0};
      endcase
      return e;
   endfunction

endpackage

// File: rtl/mbist_cfg_reg.sv
module mbist_cfg_reg #(
   parameter int IR_W      = 16,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift_en,
   input  logic            ser_in,
   output logic [IR_W-1:0] ir_q,
   output logic            ser_out
);

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ir_q <= '0;
            else if (shift_en) ir_q <= {ser_in, ir_q[IR_W-1:1]};
         end
         assign ser_out = ir_q[0];
      end else begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ir_q <= '0;
            else if (shift_en) ir_q <= {ir_q[IR_W-2:0], ser_in};
         end
         assign ser_out = ir_q[IR_W-1];
      end
   endgenerate

   AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (ser_out != $past(ser_out)) || ($past(ir_q) != ir_q) || ($past(ir_q) == {IR_W{$past(ser_in)}})) // R2
      else $error("config register did not move on shift");

   AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(ir_q)) // R1
      else $error("config register changed without shift");

endmodule

// File: rtl/mbist_march_fsm.sv
module mbist_march_fsm
   import mbist_seq_pkg::*;
#(
   parameter int N_ELEM = NUM_ELEM
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bist_en,
   input  logic             run,
   input  logic             ir_shift,
   input  logic             rsp_exp,
   input  logic             rsp_empty,
   input  logic             cfg_ckb,
   input  logic             cfg_rowf,
   output logic [CMD_W-1:0] cmd_run,
   output logic             running,
   output logic             start,
   output logic             elem_end,
   output logic             set_done
);

   localparam int EW = (N_ELEM > 1) ? $clog2(N_ELEM) : 1;
   localparam logic [EW-1:0] LAST_ELEM = EW'(N_ELEM - 1);

   seq_state_e  state;
   logic [EW-1:0] elem;
   logic        op_i;
   logic        run_q;
   march_elem_t info;
   logic        last_op;
   logic        cur_rd;
   logic        cur_val;

   assign info     = march_elem(int'(elem));
   assign last_op  = info.two_ops ? op_i : 1'b1;
   assign cur_rd   = (op_i == 1'b0) ? info.op0_rd  : 1'b0;
   assign cur_val  = (op_i == 1'b0) ? info.op0_val : info.op1_val;
   assign running  = (state == ST_ELEM) || (state == ST_OP) || (state == ST_DRAIN);
   assign start    = bist_en && run && !run_q && !ir_shift &&
                     ((state == ST_IDLE) || (state == ST_DONE));
   assign elem_end = (state == ST_OP) && last_op && rsp_exp;
   assign set_done = (state == ST_DRAIN) && rsp_empty;

   always_comb begin
      cmd_run = '0;
      case (state)
         ST_ELEM: begin
            cmd_run[C_RST]  = 1'b1;
            cmd_run[C_DOWN] = info.down;
            cmd_run[C_CKB]  = cfg_ckb;
            cmd_run[C_ROWF] = cfg_rowf;
         end
         ST_OP: begin
            cmd_run[C_RD]   = cur_rd;
            cmd_run[C_WR]   = !cur_rd;
            cmd_run[C_INV]  = cur_val;
            cmd_run[C_INC]  = last_op;
            cmd_run[C_DOWN] = info.down;
            cmd_run[C_CKB]  = cfg_ckb;
            cmd_run[C_ROWF] = cfg_rowf;
         end
         ST_DRAIN: begin
            cmd_run[C_STALL] = 1'b1;
            cmd_run[C_CKB]   = cfg_ckb;
            cmd_run[C_ROWF]  = cfg_rowf;
         end
         default: cmd_run = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= run;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         elem  <= '0;
         op_i  <= 1'b0;
      end else if (!bist_en) begin
         state <= ST_IDLE;
         elem  <= '0;
         op_i  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  state <= ST_ELEM;
                  elem  <= '0;
                  op_i  <= 1'b0;
               end
            end
            ST_ELEM: begin
               state <= ST_OP;
               op_i  <= 1'b0;
            end
            ST_OP: begin
               if (last_op) begin
                  op_i <= 1'b0;
                  if (rsp_exp) begin
                     if (elem == LAST_ELEM) state <= ST_DRAIN;
                     else begin
                        elem  <= elem + 1'b1;
                        state <= ST_ELEM;
                     end
                  end
               end else begin
                  op_i <= 1'b1;
               end
            end
            ST_DRAIN: if (rsp_empty) state <= ST_DONE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   AST_NEXT_ELEM_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (bist_en && elem_end && elem != LAST_ELEM) |=> cmd_run[C_RST]) // R7
      else $error("element end not followed by reset-address");

   AST_LAST_ELEM_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (bist_en && elem_end && elem == LAST_ELEM) |=> cmd_run[C_STALL]) // R9
      else $error("last element not followed by stall");

endmodule

// File: rtl/mbist_status.sv
module mbist_status
   import mbist_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bist_en,
   input  logic              start,
   input  logic              active,
   input  logic              fail_in,
   input  logic              elem_end,
   input  logic              set_done,
   input  logic              pulse_mode,
   output logic [STAT_W-1:0] status
);

   logic st_exp, st_fail, st_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_exp  <= 1'b0;
         st_fail <= 1'b0;
         st_done <= 1'b0;
      end else if (!bist_en || start) begin
         st_exp  <= 1'b0;
         st_fail <= 1'b0;
         st_done <= 1'b0;
      end else begin
         st_exp <= elem_end;
         if (active)          st_fail <= pulse_mode ? fail_in : (st_fail | fail_in);
         else if (pulse_mode) st_fail <= 1'b0;
         if (set_done)        st_done <= 1'b1;
      end
   end

   always_comb begin
      status         = '0;
      status[S_EXP]  = st_exp;
      status[S_FAIL] = st_fail;
      status[S_DONE] = st_done;
   end

   AST_PULSE_TRACKS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_mode && $past(pulse_mode) && st_fail) |-> $past(fail_in && active)) // R11
      else $error("pulse-mode fail without a failing compare");

   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_fail && !pulse_mode && bist_en && !start) |=> st_fail) // R10
      else $error("sticky fail dropped");

endmodule

// File: rtl/mbist_sequencer.sv
module mbist_sequencer
   import mbist_seq_pkg::*;
#(
   parameter int IR_W      = 16,
   parameter int CKB_BIT   = 0,
   parameter int ROWF_BIT  = 1,
   parameter int FAIL_BIT  = 5,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bist_en,
   input  logic              ser_in,
   input  logic              ir_shift,
   input  logic              run,
   input  logic [RSP_W-1:0]  rsp,
   output logic [CMD_W-1:0]  cmd,
   output logic [STAT_W-1:0] status
);

   generate
      if (IR_W < 2)        begin : g_bad_w    $error("IR_W too small");         end
      if (FAIL_BIT >= IR_W) begin : g_bad_fail $error("FAIL_BIT outside IR_W"); end
      if (CKB_BIT >= IR_W || ROWF_BIT >= IR_W) begin : g_bad_cfg $error("config bit outside IR_W"); end
   endgenerate

   logic [IR_W-1:0]  ir_q;
   logic             ser_out;
   logic             shift_en;
   logic [CMD_W-1:0] cmd_run;
   logic             running, start, elem_end, set_done;

   assign shift_en = bist_en && ir_shift && !running;

   mbist_cfg_reg #(.IR_W(IR_W), .LSB_FIRST(LSB_FIRST)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .ser_in   (ser_in),
      .ir_q     (ir_q),
      .ser_out  (ser_out)
   );

   mbist_march_fsm #(.N_ELEM(NUM_ELEM)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .bist_en   (bist_en),
      .run       (run),
      .ir_shift  (ir_shift),
      .rsp_exp   (rsp[R_EXP]),
      .rsp_empty (rsp[R_EMPTY]),
      .cfg_ckb   (ir_q[CKB_BIT]),
      .cfg_rowf  (ir_q[ROWF_BIT]),
      .cmd_run   (cmd_run),
      .running   (running),
      .start     (start),
      .elem_end  (elem_end),
      .set_done  (set_done)
   );

   mbist_status u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .bist_en    (bist_en),
      .start      (start),
      .active     (running),
      .fail_in    (rsp[R_FAIL]),
      .elem_end   (elem_end),
      .set_done   (set_done),
      .pulse_mode (ir_q[FAIL_BIT]),
      .status     (status)
   );

   always_comb begin
      if (!bist_en)      cmd = '0;
      else if (shift_en) cmd = CMD_W'({ser_out, 3'b000});
      else               cmd = cmd_run;
   end

   AST_DONE_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[S_DONE]) |-> $past(cmd[C_STALL] && rsp[R_EMPTY])) // R9
      else $error("done without drained pipeline");

   AST_EXPIRE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      status[S_EXP] |-> $past(cmd[C_INC] && rsp[R_EXP])) // R8
      else $error("progress pulse without expire");

   AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bist_en) |-> (status == '0)) // R1
      else $error("status not cleared while disabled");

   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd[C_RD] && cmd[C_WR])) // R6
      else $error("read and write together");

endmodule

// File: tb/mbist_sequencer_tb_top.sv
module mbist_sequencer_tb_top;

   localparam int N_ADDR = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bist_en = 1'b0;
   logic        ser_in = 1'b0;
   logic        ir_shift = 1'b0;
   logic        run = 1'b0;
   logic [2:0]  rsp;
   logic [11:0] cmd;
   logic [2:0]  status;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;   // 250 MHz

   mbist_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .ser_in(ser_in),
      .ir_shift(ir_shift), .run(run), .rsp(rsp), .cmd(cmd), .status(status)
   );

   // dispatch unit model
   int   addr_cnt = 0;
   int   stall_cnt = 0;
   int   run_cyc = 0;
   int   fail_at[3] = '{-1, -1, -1};
   logic fail_q_m = 1'b0, sticky_m = 1'b0, exp_m = 1'b0;
   logic active_tb;

   assign active_tb = bist_en && (cmd[0] || cmd[5] || cmd[6] || cmd[11]);
   assign rsp[0] = (addr_cnt == N_ADDR - 1);
   assign rsp[1] = (stall_cnt >= 3);
   assign rsp[2] = active_tb && (run_cyc == fail_at[0] || run_cyc == fail_at[1] || run_cyc == fail_at[2]);

   always @(posedge clk) begin
      if (cmd[0])      addr_cnt <= 0;
      else if (cmd[1]) addr_cnt <= addr_cnt + 1;
      if (cmd[0])       stall_cnt <= 0;
      else if (cmd[11]) stall_cnt <= stall_cnt + 1;
      run_cyc  <= active_tb ? run_cyc + 1 : 0;
      fail_q_m <= active_tb && rsp[2];
      exp_m    <= cmd[1] && rsp[0];
      if (active_tb) sticky_m <= (run_cyc == 0) ? rsp[2] : (sticky_m | rsp[2]);
   end

   logic [11:0] exp_q[$];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // shift a value in LSB first, checking the bits that leave on cmd[3] (R2)
   task automatic shift_cfg(input logic [15:0] v, input logic [15:0] prev, input bit check_out);
      for (int k = 0; k < 16; k++) begin
         @(posedge clk); #1;
         ir_shift = 1'b1;
         ser_in   = v[k];
         @(negedge clk);
         if (check_out) begin
            chk(cmd[3] == prev[k], "R2 serial out", 32'(cmd[3]), 32'(prev[k]));
            chk((cmd & 12'hFF7) == 12'h000, "R2 other bits", 32'(cmd), 32'h0);
         end
      end
      @(posedge clk); #1;
      ir_shift = 1'b0;
   endtask

   // driver: expected March C- command stream (R3, R5, R6, R9)
   task automatic drive_run(input bit ckb, input bit rowf);
      bit tdown[6] = '{0, 0, 0, 1, 1, 0};
      bit ttwo[6]  = '{0, 1, 1, 1, 1, 0};
      bit trd0[6]  = '{0, 1, 1, 1, 1, 1};
      bit tv0[6]   = '{0, 0, 1, 0, 1, 0};
      bit tv1[6]   = '{0, 1, 0, 1, 0, 0};
      logic [11:0] glob = 12'((ckb << 4) | (rowf << 7));
      for (int e = 0; e < 6; e++) begin
         exp_q.push_back(glob | 12'h001 | 12'(tdown[e] << 8));
         for (int a = 0; a < N_ADDR; a++) begin
            int nops = ttwo[e] ? 2 : 1;
            for (int o = 0; o < nops; o++) begin
               bit rd = (o == 0) ? trd0[e] : 1'b0;
               bit v  = (o == 0) ? tv0[e] : tv1[e];
               logic [11:0] c = glob | 12'(tdown[e] << 8) | (rd ? 12'h040 : 12'h020) | 12'(v << 3);
               if (o == nops - 1) c = c | 12'h002;
               exp_q.push_back(c);
            end
         end
      end
      for (int s = 0; s < 4; s++) exp_q.push_back(glob | 12'h800);
      @(posedge clk); #1;
      run = 1'b1;
   endtask

   // monitor: pops and compares as the design issues commands
   task automatic monitor_run(input bit pulse);
      int guard = 0;
      int n_exp = 0;
      bit first = 1'b1;
      do begin @(negedge clk); guard++; end while (cmd == 12'h0 && guard < 100);
      while (exp_q.size() > 0) begin
         logic [11:0] e = exp_q.pop_front();
         logic exp_fail = pulse ? fail_q_m : ((run_cyc == 0) ? 1'b0 : sticky_m);
         chk(cmd == e, "R6 command stream", 32'(cmd), 32'(e));
         chk((cmd & 12'h604) == 0, "R12 unused bits", 32'(cmd), 32'h0);
         chk(status[0] == exp_m, "R8 progress", 32'(status[0]), 32'(exp_m));
         chk(status[1] == exp_fail, pulse ? "R11 pulse fail" : "R10 sticky fail", 32'(status[1]), 32'(exp_fail));
         if (first) chk(status[2] == 1'b0, "R4 done cleared at start", 32'(status[2]), 32'h0);
         first = 1'b0;
         if (status[0]) n_exp++;
         @(negedge clk);
      end
      chk(status[0] == exp_m, "R8 progress", 32'(status[0]), 32'(exp_m));
      if (status[0]) n_exp++;
      chk(n_exp == 6, "R8 pulse count", 32'(n_exp), 32'd6);
      chk(cmd == 12'h0, "R9 idle after done", 32'(cmd), 32'h0);
      chk(status[2] == 1'b1, "R9 done", 32'(status[2]), 32'h1);
      if (!pulse) chk(status[1] == 1'b1, "R10 sticky after done", 32'(status[1]), 32'h1);
   endtask

   initial begin
      bit wd_hit = 1'b0;
      fork
         begin
            repeat (3) @(posedge clk);
            #1 rst_n = 1'b1;
            @(negedge clk);
            chk(cmd == 12'h0 && status == 3'h0, "R1 reset state", {17'h0, status, cmd}, 32'h0);
            #1 bist_en = 1'b1;
            // load an arbitrary pattern, then run-1 config while checking the pattern leaves
            shift_cfg(16'h5A3C, 16'h0000, 1'b1);
            shift_cfg(16'h0001, 16'h5A3C, 1'b1);   // checkerboard, sticky (R3)
            fail_at = '{10, 11, 48};
            fork
               drive_run(1'b1, 1'b0);
               monitor_run(1'b0);
            join
            @(posedge clk); #1 run = 1'b0;
            repeat (3) @(negedge clk);
            chk(status[2] == 1'b1 && status[1] == 1'b1, "R10 hold until start", 32'(status), 32'h6);
            // disable: status clears, shifting ignored
            @(posedge clk); #1 bist_en = 1'b0;
            @(negedge clk);
            chk(cmd == 12'h0, "R1 cmd off", 32'(cmd), 32'h0);
            @(negedge clk);
            chk(status == 3'h0, "R1 status cleared", 32'(status), 32'h0);
            shift_cfg(16'hFFFF, 16'h0000, 1'b0);
            chk(cmd == 12'h0, "R1 cmd off during shift", 32'(cmd), 32'h0);
            @(posedge clk); #1 bist_en = 1'b1;
            shift_cfg(16'h0022, 16'h0001, 1'b1);   // row-fast, pulse mode; old config proves R1 ignore
            fail_at = '{7, 8, 47};
            fork
               drive_run(1'b0, 1'b1);
               monitor_run(1'b1);
            join
            @(posedge clk); #1 run = 1'b0;
            @(negedge clk);
            chk(status[1] == 1'b0, "R11 pulse ends", 32'(status[1]), 32'h0);
         end
         begin
            repeat (20000) @(posedge clk);
            wd_hit = 1'b1;
         end
      join_any
      if (wd_hit) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule